// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources behind a single request line that feeds a parent interrupt controller. Every source owns one bit in a cause register, which latches the source while it is high, and one bit in an enable register, which decides whether that latched cause is allowed to reach the parent. A source counts as pending when both of its bits are set.

Software reaches the two registers through a plain 32-bit register port with an address, a write strobe, write data, a read strobe and read data. The cause register sits at offset 0x00. The enable register sits at offset 0x04. A handler clears a cause by writing a one to its bit. While the parent line is high, the block also presents the number of the lowest pending source. The handler can therefore go straight to that source without scanning the register.

To silence everything, software writes zero to the enable register and then writes all ones to the cause register.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, the cause and enable registers both read as zero, `irq_o` and `sel_valid_o` are low, and `sel_idx_o` is zero.
- R2: A write to offset 0x04 loads the enable register at the next clock edge, and a read of 0x04 returns it. A 1 in bit n enables source n and a 0 disables it.
- R3: A read of offset 0x00 returns the latched cause bits whether or not they are enabled, with bit n holding source n.
- R4: A read of any offset other than 0x00 or 0x04 returns zero. A write to such an offset changes neither register.
- R5: A source that is high at a clock edge sets its cause bit at that edge. The bit stays set after the source drops, until it is acknowledged.
- R6: Writing offset 0x00 clears every cause bit whose write-data bit is 1, provided its source is low. Bits written with 0 keep their value.
- R7: When a source is high in the same cycle that its cause bit is acknowledged, the bit stays set, so a level still present is latched again.
- R8: `irq_o` is registered. It is high exactly when the cause register ANDed with the enable register is non-zero, and it follows both registers at the same clock edge.
- R9: `sel_valid_o` equals `irq_o`. When it is high, `sel_idx_o` gives the lowest-numbered pending bit. When it is low, `sel_idx_o` is zero.
- R10: Writing 0 to offset 0x04 drops `irq_o` at that edge. A following write of all ones to offset 0x00, with every source low, leaves the cause register reading zero.
- R11: `rd_data_o` is registered. It shows the selected register as it stood at the clock edge where `rd_en_i` was sampled high, and it is zero in every cycle after an edge where `rd_en_i` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt sources, bit n is source n |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined request to the parent controller |
| sel_valid_o | output | 1 | A pending source is selected |
| sel_idx_o | output | 5 | Number of the lowest pending source |

## Verification
All state and outputs change at the same rising edge that samples a source change or a register write. `irq_o`, `sel_valid_o` and `sel_idx_o` are therefore due one edge after the stimulus. Read data is also due one edge after the read strobe, and it shows the register contents from before any write in that same cycle.

The driver applies inputs on the falling edge and waits for the next rising edge. It then updates a model built from the requirements and queues the expected values. The monitor compares them at the following falling edge, so every comparison falls exactly in the cycle its result is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned CAUSE_OFS = 32'h00;
    localparam int unsigned MASK_OFS  = 32'h04;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irqc_cause_reg.sv
module irqc_cause_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] cause_o,
    output logic [NSRC-1:0] cause_nxt_o
);

    typedef struct packed {
        logic [NSRC-1:0] cause;
    } cause_st_t;

    cause_st_t st_d, st_q;

    // Acknowledge clears, a live level sets; set wins on the same bit.
    always_comb begin
        st_d       = st_q;
        st_d.cause = (st_q.cause & ~ack_i) | src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o     = st_q.cause;
    assign cause_nxt_o = st_d.cause;

    AST_SRC_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cause_o & $past(src_i)) == $past(src_i))); // R5

    AST_UNACKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cause_o & $past(cause_o & ~ack_i)) == $past(cause_o & ~ack_i))); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cause_o & $past(ack_i & ~src_i)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cause_o & $past(ack_i & src_i)) == $past(ack_i & src_i))); // R7

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] mask_nxt_o
);

    typedef struct packed {
        logic [NSRC-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o     = st_q.mask;
    assign mask_nxt_o = st_d.mask;

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i))); // R2

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o)); // R4

endmodule

// File: rtl/irqc_lowest_sel.sv
module irqc_lowest_sel #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // below[i] is high when some bit under position i is pending.
    logic [NSRC:0]   below;
    logic [NSRC-1:0] grant;

    assign below[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign below[g+1] = below[g] | pend_i[g];
        assign grant[g]   = pend_i[g] & ~below[g];
    end

    // grant is one-hot or zero, so OR-ing the indices encodes it.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

    assign valid_o = below[NSRC];

endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              sel_valid_o,
    output logic [IDX_W-1:0]  sel_idx_o
);

    typedef struct packed {
        logic              irq;
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] rdata;
    } out_st_t;

    out_st_t st_d, st_q;

    reg_sel_e        reg_sel;
    logic [NSRC-1:0] ack_vec;
    logic            mask_wr;
    logic [NSRC-1:0] cause_q, cause_nxt;
    logic [NSRC-1:0] mask_q, mask_nxt;
    logic [NSRC-1:0] pend_nxt;
    logic            sel_vld_nxt;
    logic [IDX_W-1:0] sel_idx_nxt;

    always_comb begin
        if (addr_i == ADDR_W'(CAUSE_OFS)) begin
            reg_sel = SEL_CAUSE;
        end else if (addr_i == ADDR_W'(MASK_OFS)) begin
            reg_sel = SEL_MASK;
        end else begin
            reg_sel = SEL_NONE;
        end
    end

    assign ack_vec = (wr_en_i && reg_sel == SEL_CAUSE) ? wr_data_i[NSRC-1:0] : '0;
    assign mask_wr = wr_en_i && (reg_sel == SEL_MASK);

    irqc_cause_reg #(.NSRC(NSRC)) u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .ack_i       (ack_vec),
        .cause_o     (cause_q),
        .cause_nxt_o (cause_nxt)
    );

    irqc_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mask_wr),
        .wdata_i    (wr_data_i[NSRC-1:0]),
        .mask_o     (mask_q),
        .mask_nxt_o (mask_nxt)
    );

    // The outputs are registered from next-state values so they line up
    // with the registers at the same edge.
    assign pend_nxt = cause_nxt & mask_nxt;

    irqc_lowest_sel #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
        .pend_i  (pend_nxt),
        .valid_o (sel_vld_nxt),
        .idx_o   (sel_idx_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |pend_nxt;
        st_d.vld = sel_vld_nxt;
        st_d.idx = sel_idx_nxt;
        st_d.rdata = '0;
        if (rd_en_i) begin
            unique case (reg_sel)
                SEL_CAUSE: st_d.rdata = DATA_W'(cause_q);
                SEL_MASK:  st_d.rdata = DATA_W'(mask_q);
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o       = st_q.irq;
    assign sel_valid_o = st_q.vld;
    assign sel_idx_o   = st_q.idx;
    assign rd_data_o   = st_q.rdata;

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] below_sel;
    assign pend_q    = cause_q & mask_q;
    assign below_sel = (NSRC'(1) << sel_idx_o) - NSRC'(1);

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|pend_q)); // R8

    AST_VALID_IS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o == irq_o); // R9

    AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (pend_q[sel_idx_o] && ((pend_q & below_sel) == '0))); // R9

    AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_idx_o == '0)); // R9

    AST_CAUSE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(CAUSE_OFS)) |=> (rd_data_o == DATA_W'($past(cause_q)))); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i != ADDR_W'(CAUSE_OFS) && addr_i != ADDR_W'(MASK_OFS)) |=> (rd_data_o == '0)); // R4

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0)); // R11

    AST_QUIESCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(MASK_OFS) && wr_data_i == '0) |=> (!irq_o && !sel_valid_o)); // R10

endmodule

// File: tb/irqc_cascade_tb.sv
module irqc_cascade_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    logic        sel_vld;
    logic [4:0]  sel_idx;

    always #10 clk = ~clk;   // 50 MHz

    irqc_cascade dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .addr_i      (addr),
        .wr_en_i     (wr_en),
        .wr_data_i   (wdata),
        .rd_en_i     (rd_en),
        .rd_data_o   (rd_data),
        .irq_o       (irq),
        .sel_valid_o (sel_vld),
        .sel_idx_o   (sel_idx)
    );

    typedef struct {
        string       req;
        int          kind;   // 0 irq, 1 valid, 2 index, 3 read data
        logic [31:0] exp;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    logic [31:0] m_cause = '0;
    logic [31:0] m_mask  = '0;

    function automatic logic [31:0] lowest(input logic [31:0] p);
        for (int i = 0; i < 32; i++) begin
            if (p[i]) return 32'(i);
        end
        return 32'd0;
    endfunction

    task automatic push(input string req, input int kind, input logic [31:0] e);
        exp_item_t it;
        it.req = req; it.kind = kind; it.exp = e;
        sb_q.push_back(it);
    endtask

    // Rising edge, model update, expected outputs queued.
    task automatic cyc(input string req, input logic [31:0] ack,
                       input bit mwr, input logic [31:0] mdat);
        logic [31:0] p;
        @(posedge clk); #1;
        m_cause = (m_cause & ~ack) | src;
        if (mwr) m_mask = mdat;
        p = m_cause & m_mask;
        push(req, 0, {31'd0, |p});
        push(req, 1, {31'd0, |p});
        push(req, 2, lowest(p));
    endtask

    task automatic set_src(input string req, input logic [31:0] v);
        @(negedge clk); src = v;
        cyc(req, '0, 0, '0);
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        cyc(req, (a == 8'h00) ? d : 32'd0, a == 8'h04, d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        logic [31:0] e;
        @(negedge clk); addr = a; rd_en = 1'b1;
        e = (a == 8'h00) ? m_cause : (a == 8'h04) ? m_mask : 32'd0;
        cyc(req, '0, 0, '0);
        push(req, 3, e);
        @(negedge clk); rd_en = 1'b0;
        cyc("R11", '0, 0, '0);
        push("R11", 3, 32'd0);
    endtask

    // Monitor: compares queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = {31'd0, irq};
                    1:       act = {31'd0, sel_vld};
                    2:       act = {27'd0, sel_idx};
                    default: act = rd_data;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errs++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc("R1", '0, 0, '0);
        rd("R1", 8'h00);
        rd("R1", 8'h04);
        // R3: raw causes visible while disabled
        set_src("R3", 32'h0000_0208);
        rd("R3", 8'h00);
        // R2: enable source 9
        wr("R2", 8'h04, 32'h0000_0200);
        rd("R2", 8'h04);
        // R9: lower source wins once enabled
        wr("R9", 8'h04, 32'h0000_0208);
        // R5: causes remain after sources drop
        set_src("R5", 32'h0);
        rd("R5", 8'h00);
        // R6: write-one clears bit 3 only
        wr("R6", 8'h00, 32'h0000_0008);
        rd("R6", 8'h00);
        // R7: live level beats acknowledge
        set_src("R7", 32'h0000_0200);
        wr("R7", 8'h00, 32'h0000_0200);
        rd("R7", 8'h00);
        set_src("R5", 32'h0);
        wr("R6", 8'h00, 32'h0000_0200);
        rd("R6", 8'h00);
        // R4: unmapped offsets
        rd("R4", 8'h08);
        wr("R4", 8'h08, 32'hFFFF_FFFF);
        wr("R4", 8'h0C, 32'hFFFF_FFFF);
        rd("R4", 8'h04);
        rd("R4", 8'h0C);
        // R8/R9: extreme indices
        wr("R8", 8'h04, 32'hFFFF_FFFF);
        set_src("R9", 32'h8000_0000);
        set_src("R9", 32'h8000_0001);
        set_src("R8", 32'h0);
        wr("R6", 8'h00, 32'h0000_0001);
        // R10: quiesce
        wr("R10", 8'h04, 32'h0);
        wr("R10", 8'h00, 32'hFFFF_FFFF);
        rd("R10", 8'h00);
        rd("R10", 8'h04);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule